// File: doc/BRIEF.md
# UART Byte FIFO with Programmable Trigger and Flow-Control Thresholds

This block is the byte queue that sits between a UART's serial shifter and its host bus, written once and instantiated for both the receive and the transmit path. Bytes enter through a push strobe and leave through a pop strobe. The block reports its live occupancy as a byte count, a trigger flag for the interrupt logic, a sticky overrun flag and a hysteretic flow-control stop output.

A direction input selects the trigger comparison. On the receive path the flag means "enough data has arrived" (occupancy at or above the trigger level). On the transmit path it means "room to refill" (occupancy at or below the trigger level). A mode input selects where the trigger level comes from. In legacy mode, a 2-bit selector picks one of four fixed levels. In programmable mode, an arbitrary byte count is supplied directly. Flow control uses separate high and low thresholds. Stop is raised when occupancy reaches the high mark and is released only when occupancy falls to the low mark or below.

Top module: `uart_fifo_thresh`

## Requirements
- R1: While reset is asserted and after its release, the level is 0, `empty` is 1, `full` is 0, and `rdata`, `overrun` and `fc_stop` are 0.
- R2: An accepted push appends `wdata` and an accepted pop presents the oldest byte on `rdata`. Both take effect at the clock edge where they are sampled, and `level` at that edge counts accepted pushes minus accepted pops.
- R3: The capacity is DEPTH bytes (default 128). `full` is 1 exactly when `level` equals DEPTH, and `empty` is 1 exactly when `level` is 0.
- R4: A push sampled while `full` is 1 is dropped and sets `overrun` at that edge. This holds even when a pop is sampled at the same edge. `overrun` stays 1 until `clr_ovr` is sampled high with no dropped push at that edge.
- R5: A pop sampled while `empty` is 1 changes neither `rdata` nor `level`.
- R6: With `trig_is_tx` = 0, `trig_flag` is 1 exactly when `level` >= the active trigger level.
- R7: With `trig_is_tx` = 1, `trig_flag` is 1 exactly when `level` <= the active trigger level.
- R8: With `prog_mode` = 0, the active trigger level is selected by `legacy_sel`: 0 gives 1, 1 gives DEPTH/4, 2 gives DEPTH/2 and 3 gives DEPTH-2. `prog_trig` has no effect in this mode.
- R9: With `prog_mode` = 1, the active trigger level is `prog_trig`, and `legacy_sel` has no effect.
- R10: At each edge, `fc_stop` becomes 1 if `level` (before the edge) is >= `fc_hi`. Otherwise it becomes 0 if `level` is <= `fc_lo`. Otherwise it keeps its value.
- R11: A push and a pop sampled at the same edge on a FIFO that is neither empty nor full both take effect, and `level` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push | input | 1 | Append `wdata` |
| wdata | input | 8 | Byte to append |
| pop | input | 1 | Remove oldest byte into `rdata` |
| rdata | output | 8 | Last byte popped |
| level | output | 8 | Current occupancy in bytes |
| empty | output | 1 | Occupancy is zero |
| full | output | 1 | Occupancy equals DEPTH |
| trig_is_tx | input | 1 | 0: at-or-above comparison, 1: at-or-below comparison |
| prog_mode | input | 1 | 1: programmable trigger, 0: legacy selector |
| legacy_sel | input | 2 | Fixed trigger level selector |
| prog_trig | input | 8 | Programmable trigger level |
| fc_hi | input | 8 | Flow-control stop threshold |
| fc_lo | input | 8 | Flow-control resume threshold |
| trig_flag | output | 1 | Trigger condition |
| fc_stop | output | 1 | Flow-control stop request |
| clr_ovr | input | 1 | Clear the overrun flag |
| overrun | output | 1 | Sticky dropped-push flag |

## Verification
`level`, `empty`, `full`, `rdata` and `overrun` change at the same edge that samples the push, pop or clear. `trig_flag` follows `level` and the trigger inputs with no register in between. `fc_stop` is registered from the level held before the edge, so it trails a level crossing by one cycle. The bench drives inputs on the falling edge and advances a queue-based model at the rising edge. It compares every output at the next falling edge, which is where all of these results are settled.

// File: rtl/uart_fifo_thresh.sv
module uart_fifo_thresh #(
  parameter int DEPTH = 128,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic [CW-1:0] level,
  output logic          empty,
  output logic          full,
  input  logic          trig_is_tx,
  input  logic          prog_mode,
  input  logic [1:0]    legacy_sel,
  input  logic [CW-1:0] prog_trig,
  input  logic [CW-1:0] fc_hi,
  input  logic [CW-1:0] fc_lo,
  output logic          trig_flag,
  output logic          fc_stop,
  input  logic          clr_ovr,
  output logic          overrun
);
  localparam logic [CW-1:0] LV0 = CW'(1);
  localparam logic [CW-1:0] LV1 = CW'(DEPTH / 4);
  localparam logic [CW-1:0] LV2 = CW'(DEPTH / 2);
  localparam logic [CW-1:0] LV3 = CW'(DEPTH - 2);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] thr, legacy_thr;

  assign empty = (level == '0);
  assign full  = (level == CW'(DEPTH));
  wire do_push = push && !full;
  wire do_pop  = pop && !empty;

  always_comb
    case (legacy_sel)
      2'd0:    legacy_thr = LV0;
      2'd1:    legacy_thr = LV1;
      2'd2:    legacy_thr = LV2;
      default: legacy_thr = LV3;
    endcase

  assign thr       = prog_mode ? prog_trig : legacy_thr;
  assign trig_flag = trig_is_tx ? (level <= thr) : (level >= thr);

  always_ff @(posedge clk)
    if (do_push) mem[wp] <= wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wp      <= '0;
      rp      <= '0;
      level   <= '0;
      rdata   <= '0;
      overrun <= 1'b0;
      fc_stop <= 1'b0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_pop) begin
        rdata <= mem[rp];
        rp    <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      end
      level <= level + CW'(do_push) - CW'(do_pop);
      if (push && full)  overrun <= 1'b1;
      else if (clr_ovr)  overrun <= 1'b0;
      if (level >= fc_hi)      fc_stop <= 1'b1;
      else if (level <= fc_lo) fc_stop <= 1'b0;
    end

  assert_level_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CW'(DEPTH));
  assert_overrun_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    overrun && !clr_ovr |=> overrun);
  assert_full_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    push && full && !pop |=> level == $past(level) && overrun);
  assert_empty_pop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pop && empty && !push |=> $stable(rdata) && level == '0);
  assert_fc_raise_R10: assert property (@(posedge clk) disable iff (!rst_n)
    level >= fc_hi |=> fc_stop);
  assert_fc_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    level < fc_hi && level <= fc_lo |=> !fc_stop);
  assert_both_ops_R11: assert property (@(posedge clk) disable iff (!rst_n)
    push && pop && !full && !empty |=> $stable(level));
endmodule

// File: tb/tb_uart_fifo_thresh.sv
module tb_uart_fifo_thresh;
  localparam int DEPTH = 128;
  logic clk = 0, rst_n = 0;
  logic push = 0, pop = 0, trig_is_tx = 0, prog_mode = 0, clr_ovr = 0;
  logic [7:0] wdata = 0, prog_trig = 0, fc_hi = 8'd100, fc_lo = 8'd20;
  logic [1:0] legacy_sel = 0;
  logic [7:0] rdata, level;
  logic empty, full, trig_flag, fc_stop, overrun;

  uart_fifo_thresh #(.DEPTH(DEPTH)) dut (.*);

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  int q[$];
  int m_rdata = 0;
  bit m_ovr = 0, m_fc = 0;

  function automatic int exp_thr();
    if (prog_mode) return int'(prog_trig);
    case (legacy_sel)
      2'd0: return 1;
      2'd1: return DEPTH / 4;
      2'd2: return DEPTH / 2;
      default: return DEPTH - 2;
    endcase
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic compare();
    int t = exp_thr();
    bit et = trig_is_tx ? (q.size() <= t) : (q.size() >= t);
    chk("R2 level", level, q.size());
    chk("R3 full", full, q.size() == DEPTH);
    chk("R3 empty", empty, q.size() == 0);
    chk("R2/R5 rdata", rdata, m_rdata);
    chk("R4 overrun", overrun, m_ovr);
    chk("R10 fc_stop", fc_stop, m_fc);
    if (prog_mode) chk(trig_is_tx ? "R9/R7 trig" : "R9/R6 trig", trig_flag, et);
    else           chk(trig_is_tx ? "R8/R7 trig" : "R8/R6 trig", trig_flag, et);
  endtask

  task automatic step(bit pu, bit po, int d, bit clr);
    int sz;
    push = pu; pop = po; wdata = 8'(d); clr_ovr = clr;
    @(posedge clk);
    sz = q.size();
    if (sz >= fc_hi) m_fc = 1;
    else if (sz <= fc_lo) m_fc = 0;
    if (pu && sz == DEPTH) m_ovr = 1;
    else if (clr) m_ovr = 0;
    if (po && sz > 0) m_rdata = q.pop_front();
    if (pu && sz < DEPTH) q.push_back(d & 255);
    @(negedge clk);
    compare();
    push = 0; pop = 0; clr_ovr = 0;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compare(); // R1 in reset
    rst_n = 1;
    @(negedge clk);
    compare(); // R1 after release
    for (int i = 0; i < 10; i++) step(1, 0, 8'h30 + i, 0);
    for (int i = 0; i < 12; i++) step(0, 1, 0, 0); // R5 pops past empty
    for (int s = 0; s < 4; s++) begin // R8 legacy levels, R6 direction
      legacy_sel = 2'(s); prog_trig = 8'd77;
      for (int i = 0; i < 3; i++) step(1, 0, i, 0);
    end
    prog_mode = 1; prog_trig = 8'd50; legacy_sel = 2'd3; // R9
    for (int i = 0; i < DEPTH + 3; i++) step(1, 0, i * 7, 0); // R3 R4 R10
    step(1, 1, 8'hAA, 0); // R4 drop with pop at full
    step(0, 0, 0, 1);     // R4 clear
    trig_is_tx = 1; prog_trig = 8'd40; // R7
    for (int i = 0; i < DEPTH + 2; i++) step(0, 1, 0, 0);
    for (int i = 0; i < 5; i++) step(1, 0, 8'h55 + i, 0);
    for (int i = 0; i < 8; i++) step(1, 1, 8'h90 + i, 0); // R11
    step(1, 1, 8'h11, 0);
    for (int i = 0; i < 4000; i++) begin
      if (i % 500 == 0) begin
        prog_mode = $urandom_range(0, 1); trig_is_tx = $urandom_range(0, 1);
        legacy_sel = 2'($urandom_range(0, 3)); prog_trig = 8'($urandom_range(0, DEPTH));
        fc_lo = 8'($urandom_range(0, 60)); fc_hi = 8'($urandom_range(61, DEPTH));
      end
      step($urandom_range(0, 9) < 6, $urandom_range(0, 9) < 4,
           $urandom_range(0, 255), $urandom_range(0, 30) == 0);
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule